// File: doc/BRIEF.md
# Dual-Mode Booth Multiply-Accumulate Lane

This block is one multiply-accumulate lane whose radix-4 Booth partial-product datapath serves two kinds of work. In the 8-bit integer mode, the lane multiplies a signed 8-bit activation by a signed 8-bit weight. The weight is recoded into four Booth digits. Each digit selects 0, ±1 or ±2 times the activation, and the partial products are weighted by 1, 4, 16 and 64.

In the ternary mode, the same four digit slots each take a ternary weight of −1, 0 or +1 directly. No shift is applied, and each slot uses its own activation. One cycle therefore yields a four-term ternary dot product. Negative partial products are formed by bit inversion, and the +1 completion is added in the reduction sum.

The lane result either overwrites or adds into a 32-bit signed accumulator. An accumulator holding a partial result pins the operating mode, so a mode change is only taken after a clear. The updated accumulator is visible the cycle after an operand is accepted.

Top module: `booth_mac_lane`

## Requirements
- R1: After reset, `accOut` is 0, `resValid` is 0 and `activeMode` is 0 (8-bit integer mode).
- R2: In 8-bit integer mode (`activeMode`=0), an accepted operation with `accEn`=0 sets `accOut` to the signed product of `actIn[7:0]` and `wgtIn`, one cycle after `inValid`.
- R3: The 8-bit integer product is exact at the extremes: −128×−128 gives 16384, and −128×127 gives −16256.
- R4: In ternary mode (`activeMode`=1), the lane result is the sum over slots k=0..3 of `actIn[8k+7:8k]` (signed) times the ternary weight held in `wgtIn[2k+1:2k]`. The weight code 2'b01 means +1 and 2'b11 means −1.
- R5: Ternary weight code 2'b00 means 0, and the unused code 2'b10 also contributes 0.
- R6: With `accEn`=1, an accepted operation adds the lane result to `accOut`, wrapping in 32 bits.
- R7: `resValid` is high exactly in the cycle after an accepted operation, where accepted means `inValid`=1 and `accClr`=0. `accOut` holds its value when no operation is accepted and no clear is given.
- R8: `accClr` sets `accOut` to 0 in the next cycle. It takes priority over a simultaneous `inValid`, and that operation is discarded.
- R9: The mode is sampled from `modeSel` on the first operation accepted after reset or after a clear. Later changes of `modeSel` are ignored until `accClr`. `activeMode` reports the mode of the most recent accepted operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| modeSel | input | 1 | Requested mode: 0 = 8-bit integer, 1 = ternary |
| inValid | input | 1 | Operands valid this cycle |
| accEn | input | 1 | 1 = add result to accumulator, 0 = overwrite |
| accClr | input | 1 | Clear accumulator and release the mode lock |
| actIn | input | 32 | Four signed 8-bit activations; slot 0 only in integer mode |
| wgtIn | input | 8 | Signed 8-bit weight, or four 2-bit ternary codes |
| accOut | output | 32 | Signed accumulator value |
| resValid | output | 1 | Accumulator updated by an operation last cycle |
| activeMode | output | 1 | Mode of the latest accepted operation |

## Verification
The hardest condition to reach is a `modeSel` change that arrives while an accumulation is open. The bench sets this up deliberately in both directions. It starts an integer accumulation and then raises `modeSel` with four-slot ternary operands present. The reference model keeps the locked integer product, and that product differs from the ternary sum those operands would give. Clears that coincide with `inValid` are also placed in the stimulus, so that the discarded operation and the reopened mode choice are both observed.

// File: rtl/booth_lane_pkg.sv
package booth_lane_pkg;
  typedef enum logic {
    MODE_INT8 = 1'b0,
    MODE_TERN = 1'b1
  } lane_mode_e;

  // strobes from control to datapath
  typedef struct packed {
    logic clrAcc;
    logic loadAcc;
    logic addAcc;
    logic ternary;
  } lane_strobe_t;

  // one Booth digit in sign/magnitude-select form
  typedef struct packed {
    logic neg;
    logic one;
    logic two;
  } booth_digit_t;
endpackage

// File: rtl/booth_digit_enc.sv
module booth_digit_enc
  import booth_lane_pkg::*;
(
  input  logic         ternary,
  input  logic [2:0]   triplet,
  input  logic [1:0]   tcode,
  output booth_digit_t digit
);
  always_comb begin
    digit = '0;
    if (ternary) begin
      unique case (tcode)
        2'b01:   digit = '{neg: 1'b0, one: 1'b1, two: 1'b0};
        2'b11:   digit = '{neg: 1'b1, one: 1'b1, two: 1'b0};
        default: digit = '0;
      endcase
    end else begin
      unique case (triplet)
        3'b001, 3'b010: digit = '{neg: 1'b0, one: 1'b1, two: 1'b0};
        3'b011:         digit = '{neg: 1'b0, one: 1'b0, two: 1'b1};
        3'b100:         digit = '{neg: 1'b1, one: 1'b0, two: 1'b1};
        3'b101, 3'b110: digit = '{neg: 1'b1, one: 1'b1, two: 1'b0};
        default:        digit = '0;
      endcase
    end
  end
endmodule

// File: rtl/booth_lane_ctrl.sv
module booth_lane_ctrl
  import booth_lane_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         modeSel,
  input  logic         inValid,
  input  logic         accEn,
  input  logic         accClr,
  output lane_strobe_t strobe,
  output logic         activeMode,
  output logic         resValid
);
  logic       busy;
  lane_mode_e lockedMode;
  lane_mode_e effMode;
  logic       accept;

  assign accept  = inValid && !accClr;
  assign effMode = busy ? lockedMode : lane_mode_e'(modeSel);

  always_comb begin
    strobe.clrAcc  = accClr;
    strobe.loadAcc = accept && !accEn;
    strobe.addAcc  = accept && accEn;
    strobe.ternary = (effMode == MODE_TERN);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy       <= 1'b0;
      lockedMode <= MODE_INT8;
      resValid   <= 1'b0;
    end else begin
      resValid <= accept;
      if (accClr)      busy <= 1'b0;
      else if (inValid) busy <= 1'b1;
      if (accept) lockedMode <= effMode;
    end
  end

  assign activeMode = (lockedMode == MODE_TERN);
endmodule

// File: rtl/booth_lane_dp.sv
module booth_lane_dp
  import booth_lane_pkg::*;
#(
  parameter int ACT_W = 8,
  parameter int ACC_W = 32
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  lane_strobe_t               strobe,
  input  logic [(ACT_W/2)*ACT_W-1:0] actIn,
  input  logic [ACT_W-1:0]           wgtIn,
  output logic [ACC_W-1:0]           accOut
);
  localparam int DIGITS = ACT_W / 2;
  localparam int PP_W   = ACT_W + 2;
  localparam int PROD_W = 2 * ACT_W + 2;

  booth_digit_t              digit [DIGITS];
  logic signed [PROD_W-1:0]  ppExt [DIGITS];
  logic        [PROD_W-1:0]  carry [DIGITS];
  logic signed [PROD_W-1:0]  sumVal;
  logic        [ACC_W-1:0]   sumExt;
  logic        [ACC_W-1:0]   accReg;

  for (genvar i = 0; i < DIGITS; i++) begin : g_slot
    logic [2:0]             triplet;
    logic signed [PP_W-1:0] mcand;
    logic signed [PP_W-1:0] mag;
    logic [ACT_W-1:0]       actSel;

    if (i == 0) begin : g_lsb
      assign triplet = {wgtIn[1], wgtIn[0], 1'b0};
    end else begin : g_mid
      assign triplet = {wgtIn[2*i+1], wgtIn[2*i], wgtIn[2*i-1]};
    end

    booth_digit_enc u_enc (
      .ternary(strobe.ternary),
      .triplet(triplet),
      .tcode  (wgtIn[2*i+1:2*i]),
      .digit  (digit[i])
    );

    assign actSel = strobe.ternary ? actIn[i*ACT_W +: ACT_W] : actIn[ACT_W-1:0];
    assign mcand  = {{2{actSel[ACT_W-1]}}, actSel};

    always_comb begin
      if (digit[i].one)      mag = mcand;
      else if (digit[i].two) mag = mcand <<< 1;
      else                   mag = '0;
    end

    // inverted magnitude; the +1 completion goes into the reduction sum
    assign ppExt[i] = {{(PROD_W-PP_W){mag[PP_W-1] ^ digit[i].neg}},
                       (mag ^ {PP_W{digit[i].neg}})};
    assign carry[i] = {{(PROD_W-1){1'b0}}, digit[i].neg};
  end

  always_comb begin
    sumVal = '0;
    for (int i = 0; i < DIGITS; i++) begin
      if (strobe.ternary)
        sumVal = sumVal + ppExt[i] + $signed(carry[i]);
      else
        sumVal = sumVal + (ppExt[i] <<< (2*i)) + $signed(carry[i] << (2*i));
    end
  end

  assign sumExt = {{(ACC_W-PROD_W){sumVal[PROD_W-1]}}, sumVal};

  always_ff @(posedge clk) begin
    if (!rstN)               accReg <= '0;
    else if (strobe.clrAcc)  accReg <= '0;
    else if (strobe.loadAcc) accReg <= sumExt;
    else if (strobe.addAcc)  accReg <= accReg + sumExt;
  end

  assign accOut = accReg;
endmodule

// File: rtl/booth_mac_lane.sv
module booth_mac_lane
  import booth_lane_pkg::*;
#(
  parameter int ACT_W = 8,
  parameter int ACC_W = 32
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       modeSel,
  input  logic                       inValid,
  input  logic                       accEn,
  input  logic                       accClr,
  input  logic [(ACT_W/2)*ACT_W-1:0] actIn,
  input  logic [ACT_W-1:0]           wgtIn,
  output logic [ACC_W-1:0]           accOut,
  output logic                       resValid,
  output logic                       activeMode
);
  lane_strobe_t strobe;

  booth_lane_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .modeSel   (modeSel),
    .inValid   (inValid),
    .accEn     (accEn),
    .accClr    (accClr),
    .strobe    (strobe),
    .activeMode(activeMode),
    .resValid  (resValid)
  );

  booth_lane_dp #(.ACT_W(ACT_W), .ACC_W(ACC_W)) u_dp (
    .clk   (clk),
    .rstN  (rstN),
    .strobe(strobe),
    .actIn (actIn),
    .wgtIn (wgtIn),
    .accOut(accOut)
  );
endmodule

// File: rtl/booth_mac_lane_chk.sv
module booth_mac_lane_chk #(
  parameter int ACC_W = 32
) (
  input logic             clk,
  input logic             rstN,
  input logic             inValid,
  input logic             accClr,
  input logic [ACC_W-1:0] accOut,
  input logic             resValid,
  input logic             activeMode
);
  assert_valid_follows_R7: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && !accClr) |=> resValid);

  assert_no_spurious_valid_R7: assert property (@(posedge clk) disable iff (!rstN)
    !(inValid && !accClr) |=> !resValid);

  assert_idle_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    (!inValid && !accClr) |=> $stable(accOut));

  assert_clear_zero_R8: assert property (@(posedge clk) disable iff (!rstN)
    accClr |=> (accOut == '0));

  assert_mode_locked_R9: assert property (@(posedge clk) disable iff (!rstN)
    (resValid && inValid && !accClr) |=> $stable(activeMode));
endmodule

bind booth_mac_lane booth_mac_lane_chk #(.ACC_W(ACC_W)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .inValid   (inValid),
  .accClr    (accClr),
  .accOut    (accOut),
  .resValid  (resValid),
  .activeMode(activeMode)
);

// File: tb/booth_mac_lane_bench.sv
`timescale 1ns/1ps
module booth_mac_lane_bench;
  logic        clk = 1'b0;
  logic        rstN;
  logic        modeSel, inValid, accEn, accClr;
  logic [31:0] actIn;
  logic [7:0]  wgtIn;
  logic [31:0] accOut;
  logic        resValid, activeMode;

  int checks = 0;
  int errors = 0;

  // reference state
  logic [31:0] expAcc;
  bit          expValid, expBusy, expLock;

  always #10 clk = ~clk;

  booth_mac_lane u_booth_mac_lane (
    .clk(clk), .rstN(rstN), .modeSel(modeSel), .inValid(inValid),
    .accEn(accEn), .accClr(accClr), .actIn(actIn), .wgtIn(wgtIn),
    .accOut(accOut), .resValid(resValid), .activeMode(activeMode)
  );

  function automatic int tval(logic [1:0] c);
    if (c == 2'b01) return 1;
    if (c == 2'b11) return -1;
    return 0;
  endfunction

  function automatic int refProd(bit tern, logic [31:0] a, logic [7:0] w);
    int s = 0;
    if (!tern) return int'($signed(a[7:0])) * int'($signed(w));
    for (int k = 0; k < 4; k++) s += int'($signed(a[8*k +: 8])) * tval(w[2*k +: 2]);
    return s;
  endfunction

  task automatic check(string req, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic step(string req, bit v, bit en, bit clr, bit mode,
                      logic [31:0] a, logic [7:0] w);
    bit eff;
    inValid = v; accEn = en; accClr = clr; modeSel = mode; actIn = a; wgtIn = w;
    @(posedge clk);
    eff = expBusy ? expLock : mode;
    expValid = v && !clr;
    if (clr) begin
      expAcc = 0; expBusy = 0;
    end else if (v) begin
      if (en) expAcc = expAcc + 32'(refProd(eff, a, w));
      else    expAcc = 32'(refProd(eff, a, w));
      expBusy = 1; expLock = eff;
    end
    @(negedge clk);
    check(req, "accOut", longint'($signed(accOut)), longint'($signed(expAcc)));
    check(req, "resValid", longint'(resValid), longint'(expValid));
    check(req, "activeMode", longint'(activeMode), longint'(expLock));
  endtask

  initial begin
    #(20ns * 200000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rstN = 0; modeSel = 0; inValid = 0; accEn = 0; accClr = 0; actIn = '0; wgtIn = '0;
    expAcc = 0; expValid = 0; expBusy = 0; expLock = 0;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R1 reset state
    check("R1", "accOut", longint'(accOut), 0);
    check("R1", "resValid", longint'(resValid), 0);
    check("R1", "activeMode", longint'(activeMode), 0);

    // R2 integer products, overwrite
    step("R2", 1, 0, 0, 0, 32'h0000_0003, 8'hFB);   // 3 * -5
    step("R2", 1, 0, 0, 0, 32'h0000_0025, 8'h6D);   // 37 * 109
    step("R2", 1, 0, 0, 0, 32'h0000_00E9, 8'hAA);   // -23 * -86
    // R3 extremes
    step("R3", 1, 0, 0, 0, 32'h0000_0080, 8'h80);   // 16384
    step("R3", 1, 0, 0, 0, 32'h0000_0080, 8'h7F);   // -16256
    step("R3", 1, 0, 0, 0, 32'h0000_007F, 8'h80);
    // R6 accumulate
    step("R6", 1, 1, 0, 0, 32'h0000_0080, 8'h80);
    step("R6", 1, 1, 0, 0, 32'h0000_00FF, 8'h01);
    // R7 idle cycles hold
    step("R7", 0, 1, 0, 1, 32'h1234_5678, 8'h55);
    step("R7", 0, 0, 0, 0, 32'h0000_0011, 8'h22);
    // R9 mode change ignored during integer accumulation
    step("R9", 1, 1, 0, 1, 32'h8001_7F05, 8'h7D);
    step("R9", 1, 0, 0, 1, 32'h0302_0104, 8'h37);
    // R8 clear with simultaneous operation discarded
    step("R8", 1, 1, 1, 1, 32'h0000_0040, 8'h40);
    // R4 ternary after clear
    step("R4", 1, 0, 0, 1, 32'h8001_7F05, 8'h7D);  // +1,-1,-1,+1
    step("R4", 1, 1, 0, 1, 32'h8080_8080, 8'hFF);  // all -1 on -128
    step("R4", 1, 1, 0, 1, 32'h7F7F_7F7F, 8'h55);  // all +1
    // R5 zero codes
    step("R5", 1, 0, 0, 1, 32'h7F80_7F80, 8'hAA);
    step("R5", 1, 0, 0, 1, 32'h1122_3344, 8'h00);
    step("R5", 1, 0, 0, 1, 32'h0A0B_0C0D, 8'h86);  // 10,00,01,10
    // R9 back to integer requested while ternary locked
    step("R9", 1, 1, 0, 0, 32'h0505_0505, 8'h77);
    step("R8", 0, 0, 1, 0, 32'h0, 8'h0);
    step("R9", 1, 0, 0, 0, 32'h0505_0505, 8'h77);   // integer again
    step("R8", 0, 0, 1, 0, 32'h0, 8'h0);

    // mixed stream
    for (int n = 0; n < 400; n++) begin
      step("R6", 1'($urandom_range(0, 3) != 0), 1'($urandom_range(0, 3) != 0),
           1'($urandom_range(0, 15) == 0), 1'($urandom), $urandom, 8'($urandom));
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule